// File: doc/BRIEF.md
# Mode Configuration Serial Receiver

This block is a receive-only SPI slave. A host microcontroller is always the master and uses this port only to set the operating mode, never to move sample data. The host sends one 16-bit configuration word per chip-select window. The block samples the serial clock, data and chip-select lines into the system clock domain through a synchronizer. It shifts the word in, most significant bit first, and accepts it only if the window held exactly sixteen clock rising edges.

An accepted word is split into two fields. The major mode picks the active signal-processing path, and the rest of the chip reads it to select its behaviour. The minor mode refines the behaviour within that path. A framing-width flag comes from the major mode and tells the sample data serializer whether to frame 16-bit or 8-bit words.

Top module: `mode_cfg_spi_slave`

## Requirements
- R1: While reset is high, and after it is released until the first accepted word, major_mode, minor_mode and word16_frame are all zero (major mode 0 is idle).
- R2: While spi_cs_n is low, one data bit is taken from spi_mosi on each rising edge of spi_sck, most significant bit first. In the accepted word, bits 15..12 form major_mode and bits 11..0 form minor_mode.
- R3: A word takes effect only on the rising edge of spi_cs_n, and only if exactly 16 rising spi_sck edges were seen while spi_cs_n was low. The outputs change within 8 system clocks of that rising edge.
- R4: A window with fewer than 16 clock edges is discarded, and the previous outputs are kept.
- R5: A window with more than 16 clock edges is discarded, and the previous outputs are kept.
- R6: word16_frame is 1 exactly when the major_mode output equals 4'h2 (high-frequency reader). For every other major mode it is 0.
- R7: The outputs do not change while spi_cs_n is held low.
- R8: spi_sck edges seen while spi_cs_n is high shift nothing and count nothing. A following 16-edge window is still accepted in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | input | 1 | Serial clock from the host, asynchronous |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| major_mode | output | 4 | Selected processing path |
| minor_mode | output | 12 | Refinement within the major mode |
| word16_frame | output | 1 | 1: the data serializer frames 16-bit words, 0: 8-bit words |

## Verification
Random 16-bit words sent in correctly sized windows check the bit order and the way the word splits into the two fields. Windows of 15 and 17 edges, including ones that carry a word that would otherwise be valid, separate an exact-length check from a check that only requires at least 16 edges. Clock toggles sent while chip select is high show whether a counter leaks across windows. Words that pick the high-frequency reader major mode, alternated with other major modes, check that the framing flag follows that one code alone.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
    localparam int WORD_W  = 16;
    localparam int MAJOR_W = 4;
    localparam int MINOR_W = WORD_W - MAJOR_W;
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef logic [MAJOR_W-1:0] major_t;
    typedef logic [MINOR_W-1:0] minor_t;
    typedef logic [CNT_W-1:0]   bitcnt_t;

    localparam major_t MAJOR_IDLE      = '0;
    localparam major_t MAJOR_HF_READER = major_t'(2);

    typedef struct packed {
        major_t major;
        minor_t minor;
    } cfg_word_t;

    function automatic logic needs_wide_frame(major_t m);
        return m == MAJOR_HF_READER;
    endfunction
endpackage

// File: rtl/mcfg_sync.sv
module mcfg_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mcfg_shifter.sv
module mcfg_shifter
    import mcfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_s,
    input  logic      mosi_s,
    input  logic      csn_s,
    output cfg_word_t word,
    output bitcnt_t   bit_count,
    output logic      commit
);
    logic                sck_d;
    logic                csn_d;
    logic [WORD_W-1:0]   shreg;
    logic                sck_rise;
    logic                csn_rise;

    assign sck_rise = sck_s & ~sck_d;
    assign csn_rise = csn_s & ~csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d     <= 1'b0;
            csn_d     <= 1'b1;
            shreg     <= '0;
            bit_count <= '0;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
            if (csn_s) begin
                bit_count <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[WORD_W-2:0], mosi_s};
                if (bit_count != bitcnt_t'(CNT_MAX))
                    bit_count <= bit_count + 1'b1;
            end
        end
    end

    assign commit = csn_rise && (bit_count == bitcnt_t'(WORD_W));
    assign word   = cfg_word_t'(shreg);
endmodule

// File: rtl/mcfg_decode.sv
module mcfg_decode
    import mcfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  cfg_word_t word,
    output cfg_word_t cfg,
    output logic      wide
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            wide <= 1'b0;
        end else if (commit) begin
            cfg  <= word;
            wide <= needs_wide_frame(word.major);
        end
    end
endmodule

// File: rtl/mode_cfg_spi_slave.sv
module mode_cfg_spi_slave
    import mcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic [MAJOR_W-1:0] major_mode,
    output logic [MINOR_W-1:0] minor_mode,
    output logic               word16_frame
);
    logic [2:0] pins_s;
    logic       sck_s, mosi_s, csn_s;
    cfg_word_t  rx_word;
    cfg_word_t  cfg;
    bitcnt_t    bit_count;
    logic       commit;

    mcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_mosi, spi_sck}),
        .q   (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign csn_s  = pins_s[2];

    mcfg_shifter shift_i (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .csn_s     (csn_s),
        .word      (rx_word),
        .bit_count (bit_count),
        .commit    (commit)
    );

    mcfg_decode dec_i (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (rx_word),
        .cfg    (cfg),
        .wide   (word16_frame)
    );

    assign major_mode = cfg.major;
    assign minor_mode = cfg.minor;
endmodule

// File: rtl/mcfg_checker.sv
module mcfg_checker
    import mcfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               csn_s,
    input logic               commit,
    input bitcnt_t            bit_count,
    input logic [MAJOR_W-1:0] major_mode,
    input logic [MINOR_W-1:0] minor_mode,
    input logic               word16_frame
);
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (major_mode == '0 && minor_mode == '0 && !word16_frame));

    a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable({major_mode, minor_mode}) |-> $past(commit));

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        bit_count <= bitcnt_t'(CNT_MAX));

    a_r6_frame_width_tracks_major: assert property (@(posedge clk) disable iff (rst)
        word16_frame == (major_mode == MAJOR_HF_READER));

    a_r7_stable_while_selected: assert property (@(posedge clk) disable iff (rst)
        !csn_s |=> $stable({major_mode, minor_mode, word16_frame}));

    a_r8_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> bit_count == '0);
endmodule

bind mode_cfg_spi_slave mcfg_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .csn_s        (csn_s),
    .commit       (commit),
    .bit_count    (bit_count),
    .major_mode   (major_mode),
    .minor_mode   (minor_mode),
    .word16_frame (word16_frame)
);

// File: tb/mode_cfg_spi_slave_tb.sv
module mode_cfg_spi_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic [3:0]  major_mode;
    logic [11:0] minor_mode;
    logic        word16_frame;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_word = 16'h0000;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_cfg_spi_slave dut_i (
        .clk          (clk),
        .rst          (rst),
        .spi_sck      (spi_sck),
        .spi_mosi     (spi_mosi),
        .spi_cs_n     (spi_cs_n),
        .major_mode   (major_mode),
        .minor_mode   (minor_mode),
        .word16_frame (word16_frame)
    );

    function automatic logic exp_wide(logic [15:0] w);
        return w[15:12] == 4'h2;
    endfunction

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_outputs(string req);
        logic [16:0] got, want;
        got  = {major_mode, minor_mode, word16_frame};
        want = {exp_word, exp_wide(exp_word)};
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got major=%h minor=%h wide=%b expected major=%h minor=%h wide=%b",
                     req, major_mode, minor_mode, word16_frame,
                     exp_word[15:12], exp_word[11:0], exp_wide(exp_word));
        end
    endtask

    // n bits from the low end of bits, MSB of that slice first
    task automatic send_frame(logic [31:0] bits, int n);
        spi_cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = bits[i];
            wait_clk(HALF_BIT);
            spi_sck = 1'b1;
            wait_clk(HALF_BIT);
            spi_sck = 1'b0;
        end
        wait_clk(HALF_BIT);
        check_outputs("R7");
        spi_cs_n = 1'b1;
        wait_clk(10);
        if (n == 16) exp_word = bits[15:0];
    endtask

    task automatic idle_toggles(int n);
        for (int i = 0; i < n; i++) begin
            spi_mosi = i[0];
            wait_clk(HALF_BIT);
            spi_sck = 1'b1;
            wait_clk(HALF_BIT);
            spi_sck = 1'b0;
        end
        wait_clk(4);
    endtask

    initial begin
        wait_clk(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_clk(3);
        check_outputs("R1 during reset");
        wait_clk(3);
        rst = 1'b0;
        wait_clk(5);
        check_outputs("R1 after reset");

        // R2 / R6: directed HF reader word, then a non-reader word
        send_frame(32'h2A5C, 16); check_outputs("R2 R6 hf reader");
        send_frame(32'h1F0E, 16); check_outputs("R2 R6 other major");
        send_frame(32'h2001, 16); check_outputs("R6 hf reader minor 1");
        send_frame(32'h3002, 16); check_outputs("R6 neighbour code");

        // R4: short frame, R5: long frames
        send_frame(32'h2FFF, 15);           check_outputs("R4 short 15");
        send_frame(32'h1, 1);               check_outputs("R4 short 1");
        send_frame(32'h0, 0);               check_outputs("R4 empty window");
        send_frame(32'h1_2345, 17);         check_outputs("R5 long 17");
        send_frame(32'hFFFF_FFFF, 32);      check_outputs("R5 long 32");

        // R8: clock edges with chip select high, then a full frame
        idle_toggles(5);                    check_outputs("R8 idle toggles");
        send_frame(32'hC3A5, 16);           check_outputs("R8 R3 frame after toggles");
        idle_toggles(16);                   check_outputs("R8 sixteen idle toggles");

        // R3: random mix of lengths and words
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            int n;
            w = $urandom();
            if ($urandom_range(0, 3) == 0) w[15:12] = 4'h2;
            case ($urandom_range(0, 5))
                0: n = 15;
                1: n = 17;
                default: n = 16;
            endcase
            send_frame(w, n);
            check_outputs(n == 16 ? "R3 random full" : "R3 random bad length");
        end

        send_frame(32'h0000, 16); check_outputs("R2 back to idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule